// File: doc/BRIEF.md
# Per-Source Interrupt Vector Router

This block sits between seven level-sensitive interrupt request inputs and six outgoing interrupt lines. Six vector registers describe the routing. Each one holds a destination server, a priority and a source number, and the source number picks which outgoing line the vector drives. Inputs 0 and 1 share vector 0. Inputs 2 through 6 each own one vector, in order, from vector 1 to vector 5.

Every input level is captured into a status bit one clock after it is presented. A vector is active while any of its inputs has its status bit set. Each outgoing line is the OR of all active vectors that name it. A priority of all ones marks a vector as masked. The mask does not gate the line. It gates the pending flag, which each vector keeps as "active and not masked". For each line the block also exports the effective server and the priority of the vector that drives it, so that downstream logic can apply the mask and the priority itself. Software reaches the vectors and the status words through a simple word-wide register port: a write strobe with combinational read data.

Top module: `vec_router`

## Requirements
- R1: After reset, vector v (0..5) reads priority 0xFF, source field v, server 0 and pending 0. Both status words read 0 and every line is low.
- R2: Vector word layout: server in bits 55:40, priority in bits 39:32, source in bits 31:29, pending in bit 24, all other bits read 0. A write to address 0..5 replaces server, priority and source and leaves the pending bit unchanged.
- R3: Status bits follow the inputs one clock later. Address 6 shows input 0 at bit 47 and input 1 at bit 46. Address 7 shows inputs 2..6 at bits 36..32 in that order, with input 2 at bit 36. Writes to addresses 6 and 7 have no effect.
- R4: Line k is high in the cycle after an input rises when the vector of that input has source field k. This holds whether or not the vector is masked.
- R5: Vector 0 stays active while input 0 or input 1 is set. Its line falls only once both status bits are clear.
- R6: When the inputs of a vector change, its pending bit becomes "active and priority not 0xFF". An active masked vector never shows pending.
- R7: A write that sets priority 0xFF clears pending at once. A write that unmasks a vector does not set pending; the bit is set on the next input change of that vector.
- R8: A vector write whose source field (bits 31:29) is 6 or 7 is discarded, and the whole vector keeps its old value.
- R9: For each line, the export ports carry the server field shifted right by 2 (14 bits) and the priority of the lowest-numbered active vector that drives the line. Both read zero while the line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 7 | Level interrupt requests |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0..5 vectors, 6 shared status, 7 input status |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |
| line_out | output | 6 | Outgoing interrupt lines |
| line_srv | output | 84 | Effective server per line, 14 bits each, line k at bits 14k+13:14k |
| line_pri | output | 48 | Priority per line, 8 bits each, line k at bits 8k+7:8k |

## Verification
The inputs are driven one at a time, in pairs on separate vectors, and in the overlap, release and reassert orders of the shared pair. These patterns separate the shared-vector OR from a single-input path. A second vector is rerouted onto an occupied line to show which vector wins the export ports. The pending flag is stepped through mask and unmask writes while an input is held, which separates an update on input change from an update on write. Writes with source values 6 and 7 and writes carrying junk bits show that rejected and reserved fields leave the registers untouched.

// File: rtl/vec_router.sv
module vec_router #(
  parameter int SRV_W = 16,
  parameter int PRI_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [6:0]                 irq_in,
  input  logic                       reg_we,
  input  logic [2:0]                 reg_addr,
  input  logic [63:0]                reg_wdata,
  output logic [63:0]                reg_rdata,
  output logic [5:0]                 line_out,
  output logic [6*(SRV_W-2)-1:0]     line_srv,
  output logic [6*PRI_W-1:0]         line_pri
);
  localparam int NV = 6;
  localparam int EW = SRV_W - 2;
  localparam logic [PRI_W-1:0] MASKED = '1;

  logic [NV-1:0][SRV_W-1:0] v_srv;
  logic [NV-1:0][PRI_W-1:0] v_pri;
  logic [NV-1:0][2:0]       v_src;
  logic [NV-1:0]            v_pnd;
  logic [6:0]               stat;

  logic [NV-1:0] act_now, act_nxt, chg, hit, new_msk;

  wire wr_ok = reg_we && (reg_addr < 3'd6) && (reg_wdata[31:29] < 3'd6);
  wire unused_ok = ^{reg_wdata[63:56], reg_wdata[28:0]};

  assign act_now = {stat[6:2], stat[1] | stat[0]};
  assign act_nxt = {irq_in[6:2], irq_in[1] | irq_in[0]};

  always_comb begin
    chg[0] = stat[1:0] != irq_in[1:0];
    for (int v = 1; v < NV; v++) chg[v] = stat[v+1] != irq_in[v+1];
    for (int v = 0; v < NV; v++) begin
      hit[v] = wr_ok && (reg_addr == 3'(v));
      new_msk[v] = hit[v] ? (reg_wdata[39:32] == MASKED) : (v_pri[v] == MASKED);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      v_pnd <= '0;
      for (int v = 0; v < NV; v++) begin
        v_srv[v] <= '0;
        v_pri[v] <= MASKED;
        v_src[v] <= 3'(v);
      end
    end else begin
      stat <= irq_in;
      for (int v = 0; v < NV; v++) begin
        if (hit[v]) begin
          v_srv[v] <= reg_wdata[55:40];
          v_pri[v] <= reg_wdata[39:32];
          v_src[v] <= reg_wdata[31:29];
        end
        if (chg[v])      v_pnd[v] <= act_nxt[v] & ~new_msk[v];
        else if (hit[v]) v_pnd[v] <= v_pnd[v] & ~new_msk[v];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd6:    reg_rdata = {16'h0, stat[0], stat[1], 46'h0};
      3'd7:    reg_rdata = {27'h0, stat[2], stat[3], stat[4], stat[5], stat[6], 32'h0};
      default: reg_rdata = {8'h0, v_srv[reg_addr], v_pri[reg_addr], v_src[reg_addr],
                            4'h0, v_pnd[reg_addr], 24'h0};
    endcase
  end

  always_comb begin
    line_out = '0;
    line_srv = '0;
    line_pri = '0;
    for (int k = 0; k < NV; k++) begin
      for (int v = NV - 1; v >= 0; v--) begin
        if (act_now[v] && v_src[v] == 3'(k)) begin
          line_out[k] = 1'b1;
          line_srv[k*EW +: EW] = v_srv[v][SRV_W-1:2];
          line_pri[k*PRI_W +: PRI_W] = v_pri[v];
        end
      end
    end
  end
endmodule

// File: rtl/vec_router_chk.sv
module vec_router_chk #(
  parameter int SRV_W = 16,
  parameter int PRI_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [6:0]                 irq_in,
  input logic [6:0]                 stat,
  input logic                       reg_we,
  input logic [2:0]                 reg_addr,
  input logic [2:0]                 wsrc,
  input logic [5:0]                 line_out,
  input logic [5:0][SRV_W-1:0]      v_srv,
  input logic [5:0][PRI_W-1:0]      v_pri,
  input logic [5:0][2:0]            v_src,
  input logic [5:0]                 v_pnd
);
  p_status_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stat == $past(irq_in));

  p_line_any_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat) |-> (|line_out));

  p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr < 3'd6 && wsrc >= 3'd6) |=>
      ($stable(v_srv) && $stable(v_pri) && $stable(v_src)));

  for (genvar v = 0; v < 6; v++) begin : g_vec
    p_pend_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      v_pnd[v] |-> (v_pri[v] != '1));
    p_src_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      v_src[v] < 3'd6);
  end
endmodule

bind vec_router vec_router_chk #(.SRV_W(SRV_W), .PRI_W(PRI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .stat(stat),
  .reg_we(reg_we), .reg_addr(reg_addr), .wsrc(reg_wdata[31:29]),
  .line_out(line_out), .v_srv(v_srv), .v_pri(v_pri), .v_src(v_src), .v_pnd(v_pnd)
);

// File: tb/vec_router_bench.sv
`timescale 1ns/1ps
module vec_router_bench;
  localparam int EW = 14;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [6:0]  irq_in = '0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [5:0]  line_out;
  logic [6*EW-1:0] line_srv;
  logic [47:0] line_pri;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vec_router u_vec_router (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_out(line_out), .line_srv(line_srv), .line_pri(line_pri)
  );

  function automatic logic [63:0] vword(input logic [15:0] s, input logic [7:0] p,
                                        input logic [2:0] src, input logic pnd);
    return (64'(s) << 40) | (64'(p) << 32) | (64'(src) << 29) | (64'(pnd) << 24);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_in(input logic [6:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [63:0] d;
    for (int v = 0; v < 6; v++) begin
      rd(3'(v), d);
      chk("R1 vector reset", d, vword(16'h0, 8'hFF, 3'(v), 1'b0));
    end
    rd(3'd6, d); chk("R1 shared status reset", d, 64'h0);
    rd(3'd7, d); chk("R1 input status reset", d, 64'h0);
    chk("R1 lines reset", 64'(line_out), 64'h0);
  endtask

  task automatic t_fields;
    logic [63:0] d;
    wr(3'd2, vword(16'hABCD, 8'h12, 3'd2, 1'b1) | 64'hFF00_0000_1EFF_FFFF);
    rd(3'd2, d);
    chk("R2 field layout", d, vword(16'hABCD, 8'h12, 3'd2, 1'b0));
    wr(3'd7, '1);
    rd(3'd7, d); chk("R3 status word read-only", d, 64'h0);
    wr(3'd6, '1);
    rd(3'd6, d); chk("R3 shared word read-only", d, 64'h0);
  endtask

  task automatic t_status_route;
    logic [63:0] d;
    set_in(7'b1000100);
    rd(3'd7, d); chk("R3 inputs 2 and 6 status", d, 64'h11 << 32);
    rd(3'd6, d); chk("R3 shared status idle", d, 64'h0);
    chk("R4 lines for inputs 2 and 6", 64'(line_out), 64'b100010);
    set_in(7'b0000011);
    rd(3'd6, d); chk("R3 inputs 0 and 1 status", d, 64'h3 << 46);
    rd(3'd7, d); chk("R3 input status idle", d, 64'h0);
    chk("R4 line for shared pair", 64'(line_out), 64'b000001);
    set_in(7'b0000000);
    chk("R4 lines released", 64'(line_out), 64'h0);
  endtask

  task automatic t_export;
    wr(3'd5, vword(16'h0010, 8'h20, 3'd1, 1'b0));
    set_in(7'b1000000);
    chk("R4 rerouted line", 64'(line_out), 64'b000010);
    chk("R9 server shifted", 64'(line_srv[1*EW +: EW]), 64'd4);
    chk("R9 priority", 64'(line_pri[8 +: 8]), 64'h20);
    set_in(7'b1000100);
    chk("R9 lowest vector wins server", 64'(line_srv[1*EW +: EW]), 64'd0);
    chk("R9 lowest vector wins priority", 64'(line_pri[8 +: 8]), 64'hFF);
    chk("R9 idle line export zero", 64'(line_pri[40 +: 8]), 64'h0);
    set_in(7'b0000000);
    chk("R9 all exports zero", 64'(line_srv) | 64'(line_pri), 64'h0);
  endtask

  task automatic t_shared;
    set_in(7'b0000001); chk("R5 input 0 alone", 64'(line_out[0]), 64'd1);
    set_in(7'b0000011); chk("R5 both inputs", 64'(line_out[0]), 64'd1);
    set_in(7'b0000010); chk("R5 input 1 remains", 64'(line_out[0]), 64'd1);
    set_in(7'b0000000); chk("R5 both clear", 64'(line_out[0]), 64'd0);
  endtask

  task automatic t_pending;
    logic [63:0] d;
    wr(3'd0, vword(16'h0, 8'h05, 3'd0, 1'b0));
    set_in(7'b0000001);
    rd(3'd0, d); chk("R6 pending set", 64'(d[24]), 64'd1);
    set_in(7'b0000000);
    rd(3'd0, d); chk("R6 pending cleared", 64'(d[24]), 64'd0);
    set_in(7'b0000100);
    rd(3'd1, d); chk("R6 masked never pending", 64'(d[24]), 64'd0);
    chk("R4 masked vector still drives line", 64'(line_out[1]), 64'd1);
    set_in(7'b0000000);
  endtask

  task automatic t_mask_write;
    logic [63:0] d;
    set_in(7'b0000001);
    rd(3'd0, d); chk("R6 pending before mask", 64'(d[24]), 64'd1);
    wr(3'd0, vword(16'h0, 8'hFF, 3'd0, 1'b0));
    rd(3'd0, d); chk("R7 mask write clears pending", 64'(d[24]), 64'd0);
    chk("R7 line held while masked", 64'(line_out[0]), 64'd1);
    wr(3'd0, vword(16'h0, 8'h05, 3'd0, 1'b1));
    rd(3'd0, d); chk("R7 unmask leaves pending clear", 64'(d[24]), 64'd0);
    set_in(7'b0000011);
    rd(3'd0, d); chk("R7 next change sets pending", 64'(d[24]), 64'd1);
    set_in(7'b0000000);
  endtask

  task automatic t_reject;
    logic [63:0] d;
    wr(3'd3, vword(16'h1234, 8'h33, 3'd6, 1'b0));
    rd(3'd3, d); chk("R8 source 6 rejected", d, vword(16'h0, 8'hFF, 3'd3, 1'b0));
    wr(3'd3, vword(16'h1234, 8'h33, 3'd7, 1'b0));
    rd(3'd3, d); chk("R8 source 7 rejected", d, vword(16'h0, 8'hFF, 3'd3, 1'b0));
    wr(3'd3, vword(16'h1234, 8'h33, 3'd5, 1'b0));
    rd(3'd3, d); chk("R8 source 5 accepted", d, vword(16'h1234, 8'h33, 3'd5, 1'b0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_status_route();
    t_export();
    t_shared();
    t_pending();
    t_mask_write();
    t_reject();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule